// File: doc/BRIEF.md
# Dual-Rail Power Sequencer and Fault Supervisor

This block controls the bring-up of two display supply rails: a positive boost rail and a negative inverting rail. It enables the positive converter first, with its switch current limit reduced for soft start. After a fixed delay it enables the negative converter. It then checks the comparator flags of both rails against two start-up deadlines. Once both rails have come up, it runs persistence filters on the short-circuit flags. Every detected fault shuts down both converters, disconnects the load and latches. The latch is released only by an input-undervoltage event or by taking the enable low.

All timing is counted in clock ticks. The four intervals are parameters: the negative-rail start delay, the early deadline, the late deadline and the persistence window. The analog comparators and the power stages sit outside the block and are seen only as single-bit flags.

Top module: `rail_seq_supervisor`

## Requirements
- R1: Out of reset, and whenever the block is idle, both converter enables, the soft-start flag and the fault flag are low and the disconnect control is high. One cycle after `enable_i` is sampled high with `uvlo_i` low, the positive enable and the soft-start flag go high and the disconnect control goes low.
- R2: The negative enable goes high exactly `T_NEG_TICKS` cycles after the positive enable rises. In the same cycle the soft-start flag goes low.
- R3: At `T_EARLY_TICKS` cycles after the positive enable rises, the block enters the fault state if `pos_ok_i` is low or `neg_high_i` is high.
- R4: At `T_LATE_TICKS` cycles after the positive enable rises, the block enters normal running with both enables high if `neg_ok_i` is high. Otherwise it enters the fault state.
- R5: In normal running, `pos_short_i` held high for `T_PERSIST_TICKS` consecutive cycles causes the fault state.
- R6: In normal running, `neg_high_i` held high for `T_PERSIST_TICKS` consecutive cycles causes the fault state.
- R7: A short-circuit flag that drops before its persistence window completes causes no action, and its window starts again from zero.
- R8: In the fault state both enables are low, the disconnect control and `fault_o` are high, and that state holds while `enable_i` stays high and `uvlo_i` stays low, whatever the rail flags do.
- R9: `uvlo_i` high forces the idle state from any state, including the fault state, one cycle later. When it drops while `enable_i` is high, start-up begins again.
- R10: `enable_i` low forces the idle state and clears the fault latch and all timers. The next start-up runs its full timing from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Supply enable |
| uvlo_i | input | 1 | Input undervoltage flag |
| pos_ok_i | input | 1 | Positive rail in regulation |
| pos_short_i | input | 1 | Positive rail below its short threshold |
| neg_ok_i | input | 1 | Negative rail in regulation |
| neg_high_i | input | 1 | Negative rail above setpoint plus margin |
| pos_en_o | output | 1 | Positive converter enable |
| soft_start_o | output | 1 | Reduced current-limit request |
| neg_en_o | output | 1 | Negative converter enable |
| disconnect_o | output | 1 | Input/output disconnect control |
| fault_o | output | 1 | Latched fault flag |

## Verification
The in-RTL assertions check the output invariants on every cycle:
- the negative enable never runs without the positive enable;
- soft start occurs only while the positive rail is enabled alone;
- the fault-state output pattern is correct, and the latch holds while enable and undervoltage are quiet;
- undervoltage and enable-low force the block off;
- the persistence counters stay bounded.

The exact cycle of each deadline can only be shown by the bench's scenarios. These cover which flag combinations at the early and late checkpoints lead to running or to fault. They also cover a short flag that drops one cycle before its window ends, and a start-up that is aborted and then restarted.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_POS_START = 3'd1,
    ST_NEG_START = 3'd2,
    ST_RUN       = 3'd3,
    ST_FAULT     = 3'd4
  } rs_state_e;
endpackage

// File: rtl/rs_phase_timer.sv
module rs_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | (run & (cnt_q != CMAX));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  p_clr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/rs_persist_filter.sv
module rs_persist_filter #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic cond,
  output logic trip
);
  localparam int PW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [PW-1:0] LAST = PW'(LIMIT - 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          at_last;

  always_comb begin
    at_last = (cnt_q == LAST);
    if (!(arm && cond))  cnt_d = '0;
    else if (at_last)    cnt_d = cnt_q;
    else                 cnt_d = cnt_q + 1'b1;
    trip = arm && cond && at_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_drop_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !cond) |=> (cnt_q == '0));
endmodule

// File: rtl/rs_seq_fsm.sv
module rs_seq_fsm
  import rs_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] NEG_AT   = '0,
  parameter logic [W-1:0] EARLY_AT = '0,
  parameter logic [W-1:0] LATE_AT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable_i,
  input  logic         uvlo_i,
  input  logic         pos_ok_i,
  input  logic         neg_ok_i,
  input  logic         neg_high_i,
  input  logic [W-1:0] phase_cnt,
  input  logic         trip_any,
  output logic         tmr_clr,
  output logic         tmr_run,
  output logic         filt_arm,
  output logic         pos_en_o,
  output logic         soft_start_o,
  output logic         neg_en_o,
  output logic         disconnect_o,
  output logic         fault_o
);
  rs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (uvlo_i || !enable_i) begin
      state_d = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:       state_d = ST_POS_START;
        ST_POS_START: if (phase_cnt == NEG_AT) state_d = ST_NEG_START;
        ST_NEG_START: begin
          if (phase_cnt == EARLY_AT && (!pos_ok_i || neg_high_i))
            state_d = ST_FAULT;
          else if (phase_cnt == LATE_AT)
            state_d = neg_ok_i ? ST_RUN : ST_FAULT;
        end
        ST_RUN:       if (trip_any) state_d = ST_FAULT;
        ST_FAULT:     state_d = ST_FAULT;
        default:      state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  always_comb begin
    tmr_clr      = (state_q == ST_OFF);
    tmr_run      = (state_q == ST_POS_START) || (state_q == ST_NEG_START);
    filt_arm     = (state_q == ST_RUN);
    pos_en_o     = tmr_run || (state_q == ST_RUN);
    soft_start_o = (state_q == ST_POS_START);
    neg_en_o     = (state_q == ST_NEG_START) || (state_q == ST_RUN);
    disconnect_o = (state_q == ST_OFF) || (state_q == ST_FAULT);
    fault_o      = (state_q == ST_FAULT);
  end

  p_neg_needs_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
    neg_en_o |-> pos_en_o);
  p_soft_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_start_o |-> (pos_en_o && !neg_en_o));
  p_fault_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (!pos_en_o && !neg_en_o && disconnect_o));
  p_fault_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && enable_i && !uvlo_i) |=> fault_o);
  p_uvlo_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |=> (!pos_en_o && !neg_en_o && !fault_o && disconnect_o));
  p_en_low_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (!pos_en_o && !fault_o));
endmodule

// File: rtl/rail_seq_supervisor.sv
module rail_seq_supervisor #(
  parameter int T_NEG_TICKS     = 8000,
  parameter int T_EARLY_TICKS   = 10000,
  parameter int T_LATE_TICKS    = 20000,
  parameter int T_PERSIST_TICKS = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic uvlo_i,
  input  logic pos_ok_i,
  input  logic pos_short_i,
  input  logic neg_ok_i,
  input  logic neg_high_i,
  output logic pos_en_o,
  output logic soft_start_o,
  output logic neg_en_o,
  output logic disconnect_o,
  output logic fault_o
);
  localparam int TW = $clog2(T_LATE_TICKS + 1);
  localparam logic [TW-1:0] NEG_AT   = TW'(T_NEG_TICKS - 1);
  localparam logic [TW-1:0] EARLY_AT = TW'(T_EARLY_TICKS - 1);
  localparam logic [TW-1:0] LATE_AT  = TW'(T_LATE_TICKS - 1);
  localparam int NFILT = 2;

  logic [TW-1:0]    phase_cnt;
  logic             tmr_clr, tmr_run, filt_arm;
  logic [NFILT-1:0] filt_cond, filt_trip;

  assign filt_cond = {neg_high_i, pos_short_i};

  rs_phase_timer #(.W(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .run   (tmr_run),
    .cnt   (phase_cnt)
  );

  for (genvar g = 0; g < NFILT; g++) begin : g_filt
    rs_persist_filter #(.LIMIT(T_PERSIST_TICKS)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (filt_arm),
      .cond  (filt_cond[g]),
      .trip  (filt_trip[g])
    );
  end

  rs_seq_fsm #(
    .W        (TW),
    .NEG_AT   (NEG_AT),
    .EARLY_AT (EARLY_AT),
    .LATE_AT  (LATE_AT)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_i),
    .uvlo_i       (uvlo_i),
    .pos_ok_i     (pos_ok_i),
    .neg_ok_i     (neg_ok_i),
    .neg_high_i   (neg_high_i),
    .phase_cnt    (phase_cnt),
    .trip_any     (|filt_trip),
    .tmr_clr      (tmr_clr),
    .tmr_run      (tmr_run),
    .filt_arm     (filt_arm),
    .pos_en_o     (pos_en_o),
    .soft_start_o (soft_start_o),
    .neg_en_o     (neg_en_o),
    .disconnect_o (disconnect_o),
    .fault_o      (fault_o)
  );
endmodule

// File: tb/rail_seq_supervisor_tb.sv
module rail_seq_supervisor_tb;
  localparam int NEG = 8, EARLY = 10, LATE = 20, PERS = 4;
  // packed outputs {pos_en, soft_start, neg_en, disconnect, fault}
  localparam logic [4:0] V_OFF = 5'b00010;
  localparam logic [4:0] V_PS  = 5'b11000;
  localparam logic [4:0] V_NS  = 5'b10100;
  localparam logic [4:0] V_RUN = 5'b10100;
  localparam logic [4:0] V_FLT = 5'b00011;
  // {pos_ok, neg_high, neg_ok, fault at early checkpoint, running at late checkpoint}
  localparam int NV = 5;
  localparam logic [4:0] VEC [NV] = '{
    5'b10101, 5'b00110, 5'b11110, 5'b10000, 5'b01010 };

  logic clk = 1'b0;
  logic rst_n, enable_i, uvlo_i, pos_ok_i, pos_short_i, neg_ok_i, neg_high_i;
  logic pos_en_o, soft_start_o, neg_en_o, disconnect_o, fault_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rail_seq_supervisor #(.T_NEG_TICKS(NEG), .T_EARLY_TICKS(EARLY),
                        .T_LATE_TICKS(LATE), .T_PERSIST_TICKS(PERS)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .uvlo_i(uvlo_i),
    .pos_ok_i(pos_ok_i), .pos_short_i(pos_short_i), .neg_ok_i(neg_ok_i),
    .neg_high_i(neg_high_i), .pos_en_o(pos_en_o), .soft_start_o(soft_start_o),
    .neg_en_o(neg_en_o), .disconnect_o(disconnect_o), .fault_o(fault_o));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] got;
    got = {pos_en_o, soft_start_o, neg_en_o, disconnect_o, fault_o};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs %b, expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic healthy_to_run();
    pos_ok_i = 1; neg_ok_i = 1; neg_high_i = 0; pos_short_i = 0;
    enable_i = 1;
    tick(1);
    tick(LATE);
    chk("R4 healthy start reaches run", V_RUN);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; enable_i = 0; uvlo_i = 0; pos_ok_i = 0; pos_short_i = 0;
    neg_ok_i = 0; neg_high_i = 0;
    tick(3);
    chk("R1 reset state", V_OFF);
    rst_n = 1;
    tick(2);
    chk("R1 idle after reset", V_OFF);

    // start-up checkpoint table
    for (int i = 0; i < NV; i++) begin
      enable_i = 0;
      tick(2);
      chk("R10 idle between scenarios", V_OFF);
      pos_ok_i = VEC[i][4]; neg_high_i = VEC[i][3]; neg_ok_i = VEC[i][2];
      enable_i = 1;
      tick(1);
      chk("R1 positive rail first with soft start", V_PS);
      tick(NEG - 1);
      chk("R2 negative rail not yet", V_PS);
      tick(1);
      chk("R2 negative rail enabled", V_NS);
      tick(EARLY - NEG);
      chk("R3 early checkpoint", VEC[i][1] ? V_FLT : V_NS);
      tick(LATE - EARLY);
      chk("R4 late checkpoint", VEC[i][0] ? V_RUN : V_FLT);
    end

    // persistence on positive short
    enable_i = 0; tick(2);
    healthy_to_run();
    pos_short_i = 1; tick(PERS - 1); pos_short_i = 0;
    tick(3);
    chk("R7 short glitch ignored", V_RUN);
    pos_short_i = 1; tick(PERS - 1);
    chk("R7 window restarted, no fault yet", V_RUN);
    tick(1);
    chk("R5 positive short persisted", V_FLT);
    pos_short_i = 0; pos_ok_i = 1; tick(5);
    chk("R8 fault latched after flag clears", V_FLT);
    enable_i = 0; tick(1);
    chk("R10 enable low clears latch", V_OFF);
    enable_i = 1; tick(1);
    chk("R10 restart after toggle", V_PS);
    tick(LATE);
    chk("R4 run after restart", V_RUN);

    // negative high persistence, glitch then fault
    neg_high_i = 1; tick(PERS - 1); neg_high_i = 0; tick(2);
    chk("R7 negative glitch ignored", V_RUN);
    neg_high_i = 1; tick(PERS);
    chk("R6 negative high persisted", V_FLT);
    neg_high_i = 0;
    uvlo_i = 1; tick(1);
    chk("R9 undervoltage clears latch", V_OFF);
    tick(3);
    chk("R9 held off during undervoltage", V_OFF);
    uvlo_i = 0; tick(1);
    chk("R9 restart after undervoltage", V_PS);

    // undervoltage mid start-up
    tick(NEG + 1);
    uvlo_i = 1; tick(1);
    chk("R9 undervoltage aborts start", V_OFF);
    uvlo_i = 0;

    // abort and restart timing
    tick(1);
    tick(3);
    enable_i = 0; tick(1);
    chk("R10 enable low aborts start", V_OFF);
    enable_i = 1; tick(1);
    chk("R10 fresh start", V_PS);
    tick(NEG - 1);
    chk("R10 timer restarted from zero", V_PS);
    tick(1);
    chk("R10 negative after full delay", V_NS);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule